// File: doc/BRIEF.md
# Low-Power Domain Register Write Synchronizer

This block carries register writes from a fast bus clock domain into a slow (32.768 kHz class) low-power clock domain. A write to any target address is captured in a bus-side holding register. It crosses the domain boundary through a toggle request and returns through a toggle acknowledge, each passing a flop synchronizer. The write is then presented on the slow side as a one-cycle write strobe with its address and data. Only one write is in flight at a time.

Software tracks progress through a status word on the bus side. A busy flag and its inverse, a ready-for-next flag, show whether a write is in flight. A complete flag is set when the acknowledge comes back, and it clears itself when the status word is read. An error flag records a write that arrived while another was still in flight; that write is dropped, and the flag clears only when a 1 is written to it. Writes to the status word and to the interrupt-enable word are handled at bus speed and never enter the synchronizer.

The interrupt output is the OR of five enabled events: ready-for-next, complete, error, and two external event levels (a clock alarm and a security violation) that are shown in the status word unchanged.

Top module: `lp_write_sync`

## Requirements
- R1: After reset the status word reads 0x08 (only ready-for-next set), the interrupt-enable word reads 0, the slow-side strobe is low and `irq_o` is low.
- R2: A write to an address other than 0 or 1, accepted while idle, appears on `lp_we_o`, `lp_addr_o` and `lp_data_o` at the fourth rising slow-clock edge after the bus edge that accepted it.
- R3: Busy (status bit 2) is set by the accepting bus edge and clears on the third rising bus edge after the slow-side update. Ready-for-next (status bit 3) is always the inverse of busy.
- R4: Complete (status bit 0) is set on the bus edge where busy clears. A status read (`rd_en_i` with `rd_addr_i` = 0) clears it at that edge, unless completion is being set on the same edge; in that case the set wins.
- R5: A write to a target address while busy sets error (status bit 1). That write is discarded: it causes no extra strobe, and it does not change the address or data delivered for the write in flight.
- R6: Error stays set until a write to address 0 with data bit 1 high. A write to address 0 with bit 1 low leaves error unchanged.
- R7: A write to address 1 loads the interrupt enables (bits 4:0) on that bus edge. It never sets busy, complete or error, including when it is issued while busy.
- R8: `irq_o` is high exactly when some enabled event is active. The enable bits are 0 ready-for-next, 1 complete, 2 error, 3 alarm, 4 violation.
- R9: `lp_we_o` is high for exactly one slow-clock cycle per accepted write.
- R10: Reads are combinational. Address 0 returns {violation at bit 5, alarm at bit 4, ready-for-next, busy, error, complete}. Address 1 returns the enables. Any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| slow_clk_i | input | 1 | Low-power domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | ADDR_W | Bus write address |
| wr_data_i | input | DATA_W | Bus write data |
| rd_en_i | input | 1 | Bus read strobe (status read clears complete) |
| rd_addr_i | input | ADDR_W | Bus read address |
| rd_data_o | output | DATA_W | Read data, combinational |
| alarm_i | input | 1 | Clock-alarm event level |
| viol_i | input | 1 | Security-violation event level |
| irq_o | output | 1 | Combined interrupt |
| lp_we_o | output | 1 | Slow-domain write strobe |
| lp_addr_o | output | ADDR_W | Slow-domain write address |
| lp_data_o | output | DATA_W | Slow-domain write data |

## Verification
The bench builds the block with its defaults: two synchronizer stages, a 4-bit address and 32-bit data. It runs the slow clock at one eighth of the bus rate, with its edges placed on bus falling edges, so that every hand-off has a latency fixed in bus cycles. Writes are issued after idle gaps of varying length. This sweeps the accepting edge across all eight phases of the slow clock and brings the complete-set against read-clear collision into reach. Back-to-back writes, interrupt-enable writes during a pending transfer, and writes of 0 and 1 to the error bit cover the discard and sticky-flag cases.

// File: rtl/lsync_pkg.sv
package lsync_pkg;
  localparam int unsigned ADDR_STATUS = 0;
  localparam int unsigned ADDR_IEN    = 1;

  localparam int unsigned ST_DONE  = 0;
  localparam int unsigned ST_ERR   = 1;
  localparam int unsigned ST_BUSY  = 2;
  localparam int unsigned ST_NEXT  = 3;
  localparam int unsigned ST_ALARM = 4;
  localparam int unsigned ST_VIOL  = 5;
  localparam int unsigned ST_W     = 6;

  localparam int unsigned IE_NEXT  = 0;
  localparam int unsigned IE_DONE  = 1;
  localparam int unsigned IE_ERR   = 2;
  localparam int unsigned IE_ALARM = 3;
  localparam int unsigned IE_VIOL  = 4;
  localparam int unsigned IE_W     = 5;
endpackage

// File: rtl/lsync_sync.sv
module lsync_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lsync_tx.sv
module lsync_tx #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_tgl_i,
  output logic              req_tgl_o,
  output logic [ADDR_W-1:0] hold_addr_o,
  output logic [DATA_W-1:0] hold_data_o,
  output logic              busy_o,
  output logic              land_o
);
  logic              ack_s, ack_q, req_q, busy_q, land;
  logic [ADDR_W-1:0] hold_addr_q;
  logic [DATA_W-1:0] hold_data_q;

  lsync_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_tgl_i),
    .q_o   (ack_s)
  );

  assign land = ack_s ^ ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q       <= 1'b0;
      req_q       <= 1'b0;
      busy_q      <= 1'b0;
      hold_addr_q <= '0;
      hold_data_q <= '0;
    end else begin
      ack_q <= ack_s;
      if (land) begin
        busy_q <= 1'b0;
      end else if (start_i && !busy_q) begin
        busy_q      <= 1'b1;
        req_q       <= ~req_q;
        hold_addr_q <= addr_i;
        hold_data_q <= data_i;
      end
    end
  end

  assign req_tgl_o   = req_q;
  assign hold_addr_o = hold_addr_q;
  assign hold_data_o = hold_data_q;
  assign busy_o      = busy_q;
  assign land_o      = land;

  // holding register must not move while the slow side may sample it
  p_hold_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q)) |-> ($stable(hold_data_q) && $stable(hold_addr_q)));
  p_land_when_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    land |-> busy_q);
  p_land_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    land |=> !busy_q);
endmodule

// File: rtl/lsync_rx.sv
module lsync_rx #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic              slow_clk_i,
  input  logic              rst_ni,
  input  logic              req_tgl_i,
  input  logic [ADDR_W-1:0] hold_addr_i,
  input  logic [DATA_W-1:0] hold_data_i,
  output logic              ack_tgl_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              req_s, req_q, pend_q, ack_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  lsync_sync #(.STAGES(STAGES)) u_req_sync (
    .clk_i (slow_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_tgl_i),
    .q_o   (req_s)
  );

  always_ff @(posedge slow_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      req_q  <= req_s;
      pend_q <= req_s ^ req_q;
      we_q   <= pend_q;
      if (pend_q) begin
        addr_q <= hold_addr_i;
        data_q <= hold_data_i;
        ack_q  <= ~ack_q;
      end
    end
  end

  assign ack_tgl_o = ack_q;
  assign we_o      = we_q;
  assign addr_o    = addr_q;
  assign data_o    = data_q;

  p_we_pulse_r9: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    we_q |=> !we_q);
  p_ack_with_we_r2: assert property (@(posedge slow_clk_i) disable iff (!rst_ni)
    !$stable(ack_q) |-> we_q);
endmodule

// File: rtl/lp_write_sync.sv
module lp_write_sync
  import lsync_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              slow_clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              alarm_i,
  input  logic              viol_i,
  output logic              irq_o,
  output logic              lp_we_o,
  output logic [ADDR_W-1:0] lp_addr_o,
  output logic [DATA_W-1:0] lp_data_o
);
  logic              wr_status, wr_ien, wr_slow, rd_status;
  logic              busy, land, start, collide;
  logic              req_tgl, ack_tgl;
  logic [ADDR_W-1:0] hold_addr;
  logic [DATA_W-1:0] hold_data;
  logic              err_q, done_q;
  logic [IE_W-1:0]   ien_q, evt;
  logic [ST_W-1:0]   status;

  assign wr_status = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_STATUS));
  assign wr_ien    = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_IEN));
  assign wr_slow   = wr_en_i && !wr_status && !wr_ien;
  assign rd_status = rd_en_i && (rd_addr_i == ADDR_W'(ADDR_STATUS));
  assign start     = wr_slow && !busy;
  assign collide   = wr_slow && busy;

  lsync_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGES(STAGES)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .addr_i     (wr_addr_i),
    .data_i     (wr_data_i),
    .ack_tgl_i  (ack_tgl),
    .req_tgl_o  (req_tgl),
    .hold_addr_o(hold_addr),
    .hold_data_o(hold_data),
    .busy_o     (busy),
    .land_o     (land)
  );

  lsync_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAGES(STAGES)) u_rx (
    .slow_clk_i (slow_clk_i),
    .rst_ni     (rst_ni),
    .req_tgl_i  (req_tgl),
    .hold_addr_i(hold_addr),
    .hold_data_i(hold_data),
    .ack_tgl_o  (ack_tgl),
    .we_o       (lp_we_o),
    .addr_o     (lp_addr_o),
    .data_o     (lp_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      done_q <= 1'b0;
      ien_q  <= '0;
    end else begin
      if (collide)                               err_q <= 1'b1;
      else if (wr_status && wr_data_i[ST_ERR])   err_q <= 1'b0;
      // completion set outranks a concurrent clearing read
      if (land)           done_q <= 1'b1;
      else if (rd_status) done_q <= 1'b0;
      if (wr_ien) ien_q <= wr_data_i[IE_W-1:0];
    end
  end

  always_comb begin
    status           = '0;
    status[ST_DONE]  = done_q;
    status[ST_ERR]   = err_q;
    status[ST_BUSY]  = busy;
    status[ST_NEXT]  = !busy;
    status[ST_ALARM] = alarm_i;
    status[ST_VIOL]  = viol_i;
  end

  always_comb begin
    evt           = '0;
    evt[IE_NEXT]  = !busy;
    evt[IE_DONE]  = done_q;
    evt[IE_ERR]   = err_q;
    evt[IE_ALARM] = alarm_i;
    evt[IE_VIOL]  = viol_i;
  end

  assign irq_o = |(ien_q & evt);

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(ADDR_STATUS))   rd_data_o[ST_W-1:0] = status;
    else if (rd_addr_i == ADDR_W'(ADDR_IEN)) rd_data_o[IE_W-1:0] = ien_q;
  end

  p_collide_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    collide |=> err_q);
  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !(wr_status && wr_data_i[ST_ERR])) |=> err_q);
  p_read_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_status && !land) |=> !done_q);
  p_busy_fall_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> done_q);
  p_ien_local_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ien && !busy) |=> (!busy && $stable(done_q)));
endmodule

// File: tb/lp_write_sync_bench.sv
module lp_write_sync_bench;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          slow_clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          alarm = 1'b0;
  logic          viol = 1'b0;
  logic [DW-1:0] rd_data;
  logic          irq, lp_we;
  logic [AW-1:0] lp_addr;
  logic [DW-1:0] lp_data;

  int n_cmp = 0;
  int n_bad = 0;
  int n_rise = 0;
  int div = 0;

  lp_write_sync u_lp_write_sync (
    .clk_i(clk), .slow_clk_i(slow_clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .alarm_i(alarm), .viol_i(viol), .irq_o(irq),
    .lp_we_o(lp_we), .lp_addr_o(lp_addr), .lp_data_o(lp_data)
  );

  always #2.5 clk = ~clk;

  // slow clock: 8 bus periods, edges on bus falling edges
  always @(negedge clk) begin
    if (div == 3) begin
      div <= 0;
      slow_clk <= ~slow_clk;
      if (!slow_clk) n_rise <= n_rise + 1;
    end else begin
      div <= div + 1;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  logic          m_busy, m_err, m_done, m_we;
  logic [4:0]    m_ien;
  logic [AW-1:0] m_haddr, m_laddr;
  logic [DW-1:0] m_hdata, m_ldata;
  int            m_cs, m_cb, seen_rise;

  function automatic logic [DW-1:0] exp_rd(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    v = '0;
    if (a == 0) v[5:0] = {viol, alarm, !m_busy, m_busy, m_err, m_done};
    else if (a == 1) v[4:0] = m_ien;
    return v;
  endfunction

  initial begin
    logic          c_rst, c_we, c_rd, done_now, nb;
    logic [AW-1:0] c_wa, c_ra;
    logic [DW-1:0] c_wd, e;
    seen_rise = 0;
    forever begin
      @(posedge clk);
      c_rst = rst_n; c_we = wr_en; c_wa = wr_addr; c_wd = wr_data; c_rd = rd_en; c_ra = rd_addr;
      #4;
      if (!c_rst) begin
        m_busy = 0; m_err = 0; m_done = 0; m_we = 0; m_ien = '0;
        m_haddr = '0; m_hdata = '0; m_laddr = '0; m_ldata = '0; m_cs = -1; m_cb = -1;
        seen_rise = n_rise;
      end else begin
        done_now = 0;
        if (m_cb >= 0) begin
          m_cb++;
          if (m_cb == 3) begin done_now = 1; m_cb = -1; end
        end
        nb = m_busy;
        if (c_we) begin
          if (c_wa == 0) begin
            if (c_wd[1]) m_err = 0;
          end else if (c_wa == 1) begin
            m_ien = c_wd[4:0];
          end else if (m_busy) begin
            m_err = 1;
          end else begin
            nb = 1; m_haddr = c_wa; m_hdata = c_wd; m_cs = 0;
          end
        end
        if (c_rd && c_ra == 0) m_done = 0;
        if (done_now) begin m_done = 1; nb = 0; end
        m_busy = nb;
        if (n_rise != seen_rise) begin
          seen_rise = n_rise;
          m_we = 0;
          if (m_cs >= 0) begin
            m_cs++;
            if (m_cs == 4) begin
              m_we = 1; m_laddr = m_haddr; m_ldata = m_hdata; m_cs = -1; m_cb = 0;
            end
          end
        end
        // every-clock comparison
        chk("R2 lp_addr", DW'(lp_addr), DW'(m_laddr));
        chk("R2 lp_data", lp_data, m_ldata);
        chk("R9 lp_we", DW'(lp_we), DW'(m_we));
        e = exp_rd(rd_addr);
        chk("R10 rd_data", rd_data, e);
        if (rd_addr == 0) begin
          chk("R3 busy", DW'(rd_data[2]), DW'(m_busy));
          chk("R3 next", DW'(rd_data[3]), DW'(!m_busy));
          chk("R4 done", DW'(rd_data[0]), DW'(m_done));
          chk("R6 err", DW'(rd_data[1]), DW'(m_err));
        end
        chk("R8 irq", DW'(irq),
            DW'(|(m_ien & {viol, alarm, m_err, m_done, !m_busy})));
      end
    end
  end

  task automatic cyc(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                     input logic rd, input logic [AW-1:0] ra);
    @(posedge clk); #1;
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = rd; rd_addr = ra;
  endtask

  task automatic idle(input int n, input logic rd);
    for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, rd, '0);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%0d exp=done", n_cmp);
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(2, 1'b0);
    #2;
    chk("R1 status after reset", rd_data, 32'h08);
    chk("R1 irq after reset", DW'(irq), 0);
    chk("R1 lp_we after reset", DW'(lp_we), 0);
    rd_addr = 1; #0.5;
    chk("R1 ien after reset", rd_data, 0);
    rd_addr = 0;

    // single write
    cyc(1'b1, 4'd5, 32'hA5A5_0001, 1'b0, '0);
    idle(50, 1'b0);
    #2;
    chk("R2 landed data", lp_data, 32'hA5A5_0001);
    chk("R4 done set", DW'(rd_data[0]), 1);
    cyc(1'b0, '0, '0, 1'b1, '0);
    idle(1, 1'b0);
    #2;
    chk("R4 done cleared by read", DW'(rd_data[0]), 0);

    // collision: second write dropped
    cyc(1'b1, 4'd6, 32'h0000_BEEF, 1'b0, '0);
    cyc(1'b1, 4'd7, 32'hDEAD_0000, 1'b0, '0);
    idle(50, 1'b0);
    #2;
    chk("R5 err set", DW'(rd_data[1]), 1);
    chk("R5 first write kept addr", DW'(lp_addr), 6);
    chk("R5 first write kept data", lp_data, 32'h0000_BEEF);

    // error clear semantics
    cyc(1'b1, 4'd0, 32'h0000_0000, 1'b0, '0);
    idle(1, 1'b0);
    #2;
    chk("R6 err kept on zero write", DW'(rd_data[1]), 1);
    cyc(1'b1, 4'd0, 32'h0000_0002, 1'b0, '0);
    idle(1, 1'b0);
    #2;
    chk("R6 err cleared on one", DW'(rd_data[1]), 0);

    // enables and interrupt
    cyc(1'b1, 4'd1, 32'h0000_0001, 1'b0, '0);
    idle(1, 1'b0);
    #2;
    chk("R7 ien write not busy", DW'(rd_data[2]), 0);
    chk("R8 irq on next", DW'(irq), 1);
    cyc(1'b1, 4'd1, 32'h0000_0008, 1'b0, '0);
    idle(1, 1'b0);
    #2;
    chk("R8 irq masked", DW'(irq), 0);
    alarm = 1'b1; #0.5;
    chk("R8 irq on alarm", DW'(irq), 1);
    alarm = 1'b0;
    cyc(1'b1, 4'd1, 32'h0000_0016, 1'b0, '0);
    viol = 1'b1;
    idle(3, 1'b0);
    viol = 1'b0;

    // enable write while busy: no error
    cyc(1'b1, 4'd3, 32'h1234_5678, 1'b0, '0);
    cyc(1'b1, 4'd1, 32'h0000_0002, 1'b0, '0);
    idle(1, 1'b0);
    #2;
    chk("R7 ien during busy no err", DW'(rd_data[1]), 0);
    chk("R7 busy unaffected", DW'(rd_data[2]), 1);
    idle(45, 1'b0);

    // phase sweep, some with continuous status reads
    for (int g = 0; g < 16; g++) begin
      cyc(1'b1, AW'(2 + (g % 14)), DW'(32'hC000_0000 + g), 1'b0, '0);
      idle(36 + g, g[0]);
    end

    // back-to-back bursts across phases
    for (int g = 0; g < 8; g++) begin
      cyc(1'b1, 4'd9, DW'(g), 1'b0, '0);
      cyc(1'b1, 4'd10, DW'(g + 100), 1'b0, '0);
      idle(g, 1'b0);
      cyc(1'b1, 4'd0, 32'h2, 1'b0, '0);
      idle(40, 1'b1);
    end
    idle(5, 1'b0);
    finish_run();
  end
endmodule